// File: doc/BRIEF.md
# External Pin Interrupt Sensing Unit

This block watches up to seven external interrupt pins and turns them into one interrupt request per line for a downstream interrupt controller. Each line can be set to respond to a low level, a rising edge, a falling edge or either edge. Edge events are held in a sticky flag that software must acknowledge by writing a one. Pins can also be turned around as general outputs, and then they take no part in interrupt detection.

Software reaches the unit through a small 16-bit register bus. The bus has a halfword index, a write strobe, two byte-lane enables and write data. Read data is registered and appears one cycle after the index is presented. Pin inputs pass through a synchroniser before any detection. Line position 0 is reserved and never produces a request.

Top module: `xirq_edge_unit`

## Requirements
- R1: After reset, every software register reads zero, `irq` is zero, and `pin_dir` and `pin_dout` are zero: all lines are inputs in level mode with requests disabled.
- R2: The sense field of line n sits at bits [2n+1:2n] of index 0; 00 selects level mode. In level mode an enabled input line drives `irq[n]` while its synchronised pin is low, with no latching. Bit n of index 3 then reads the live condition. The request appears within four clock edges of the pin change.
- R3: Sense 01 (rising) sets the line's flag on a synchronised 0-to-1 transition only. The flag, and `irq[n]` when enabled, stay set after the pin returns low.
- R4: Sense 10 (falling) sets the flag on a 1-to-0 transition only.
- R5: Sense 11 sets the flag on either transition.
- R6: A write to index 3 with byte lane 0 enabled clears each flag whose bit in wdata[7:0] is 1. A 0 bit leaves its flag unchanged.
- R7: If an edge event and a clearing write for the same line land on the same clock edge, the flag stays set.
- R8: Index 1 bits [7:0] are the enable bits. `irq[n]` is high only if enable n was set one cycle earlier. A flag is still captured while the line is disabled.
- R9: Index 1 bits [15:8] are the direction bits, where 1 means output. An output line never sets its flag and never requests.
- R10: Bit 0 of every register reads 0 and ignores writes. `irq[0]` is always 0.
- R11: Byte lane 1 (`bus_be[1]`) writes bits [15:8] and byte lane 0 writes bits [7:0]. A write to one lane leaves the other byte unchanged.
- R12: Index 2 bits [15:8] hold the output data and drive `pin_dout`. `pin_dir` mirrors the direction bits. Index 2 bits [7:0] read the synchronised pins and ignore writes.
- R13: `bus_rdata` shows the register selected by `bus_addr` at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Halfword register index |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 8 | External pin levels |
| pin_dout | output | 8 | Output data for pins set as outputs |
| pin_dir | output | 8 | Per-pin direction, 1 = output |
| irq | output | 8 | Per-line interrupt request |

## Verification
The hardest case to reach from the ports is an edge event that meets a clearing write on the same clock edge. The event exists only in the cycle after the second synchroniser stage changes. The stimulus therefore changes the pin on a falling clock edge and holds the clearing write back by exactly two cycles, so that both land on one edge, and then reads the flag back. A seeded random phase follows. It mixes pin toggles with writes of random index, lane and data, and a cycle-level reference model in the bench predicts every request and every read result.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    REG_SENSE = 2'd0,
    REG_CTRL  = 2'd1,
    REG_PINS  = 2'd2,
    REG_FLAGS = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xirq_line.sv
module xirq_line
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_s,
  input  logic [1:0] sense,
  input  logic       is_input,
  input  logic       clr,
  output logic       flag_q,
  output logic       lvl_hit
);
  logic prev_q;
  logic rise, fall, evt;

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;

  always_comb begin
    case (sense_e'(sense))
      SENSE_RISE: evt = rise;
      SENSE_FALL: evt = fall;
      SENSE_BOTH: evt = rise | fall;
      default:    evt = 1'b0;
    endcase
    evt = evt & is_input;
  end

  assign lvl_hit = is_input & ~pin_s & (sense_e'(sense) == SENSE_LEVEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (sense_e'(sense) == SENSE_LEVEL) flag_q <= 1'b0;
      else                                flag_q <= evt | (flag_q & ~clr);
    end
  end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr,
  input  logic [DATA_W/BYTE_W-1:0] be,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [NUM_LINES-1:0]   flag_view,
  input  logic [NUM_LINES-1:0]   pin_sync,
  output logic [2*NUM_LINES-1:0] cfg_q,
  output logic [NUM_LINES-1:0]   dir_q,
  output logic [NUM_LINES-1:0]   en_q,
  output logic [NUM_LINES-1:0]   dout_q,
  output logic [NUM_LINES-1:0]   clr_v,
  output logic [DATA_W-1:0]      rdata
);
  localparam int CFG_W = 2 * NUM_LINES;
  localparam logic [NUM_LINES-1:0] LINE_MASK = {{(NUM_LINES-1){1'b1}}, 1'b0};

  reg_idx_e idx;
  logic [DATA_W-1:0] rd_next;

  assign idx = reg_idx_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      dout_q <= '0;
    end else if (wr) begin
      case (idx)
        REG_SENSE: begin
          for (int i = 1; i < NUM_LINES; i++) begin
            if (be[(2*i)/BYTE_W]) cfg_q[2*i +: 2] <= wdata[2*i +: 2];
          end
        end
        REG_CTRL: begin
          if (be[1]) dir_q <= wdata[BYTE_W +: NUM_LINES] & LINE_MASK;
          if (be[0]) en_q  <= wdata[0 +: NUM_LINES] & LINE_MASK;
        end
        REG_PINS: begin
          if (be[1]) dout_q <= wdata[BYTE_W +: NUM_LINES] & LINE_MASK;
        end
        default: ;
      endcase
    end
  end

  assign clr_v = (wr && idx == REG_FLAGS && be[0]) ?
                 (wdata[0 +: NUM_LINES] & LINE_MASK) : '0;

  always_comb begin
    rd_next = '0;
    case (idx)
      REG_SENSE: rd_next[CFG_W-1:0] = cfg_q;
      REG_CTRL: begin
        rd_next[BYTE_W +: NUM_LINES] = dir_q;
        rd_next[0 +: NUM_LINES]      = en_q;
      end
      REG_PINS: begin
        rd_next[BYTE_W +: NUM_LINES] = dout_q;
        rd_next[0 +: NUM_LINES]      = pin_sync & LINE_MASK;
      end
      default: rd_next[0 +: NUM_LINES] = flag_view & LINE_MASK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/xirq_edge_unit.sv
module xirq_edge_unit
  import xirq_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [DATA_W/BYTE_W-1:0] bus_be,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NUM_LINES-1:0]     pin_in,
  output logic [NUM_LINES-1:0]     pin_dout,
  output logic [NUM_LINES-1:0]     pin_dir,
  output logic [NUM_LINES-1:0]     irq
);
  logic [NUM_LINES-1:0]   pin_s;
  logic [2*NUM_LINES-1:0] cfg_q;
  logic [NUM_LINES-1:0]   dir_q, en_q, dout_q, clr_v;
  logic [NUM_LINES-1:0]   flag_q, lvl_hit, flag_view;
  logic [NUM_LINES-1:0]   irq_q;

  xirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  xirq_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .be(bus_be),
    .wdata(bus_wdata), .flag_view(flag_view), .pin_sync(pin_s),
    .cfg_q(cfg_q), .dir_q(dir_q), .en_q(en_q), .dout_q(dout_q),
    .clr_v(clr_v), .rdata(bus_rdata)
  );

  assign flag_q[0]    = 1'b0;
  assign lvl_hit[0]   = 1'b0;
  assign flag_view[0] = 1'b0;

  generate
    for (genvar n = 1; n < NUM_LINES; n++) begin : g_line
      xirq_line u_line (
        .clk(clk), .rst(rst), .pin_s(pin_s[n]), .sense(cfg_q[2*n +: 2]),
        .is_input(~dir_q[n]), .clr(clr_v[n]),
        .flag_q(flag_q[n]), .lvl_hit(lvl_hit[n])
      );
      assign flag_view[n] = (sense_e'(cfg_q[2*n +: 2]) == SENSE_LEVEL) ?
                            lvl_hit[n] : flag_q[n];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= en_q & flag_view;
  end

  assign irq      = irq_q;
  assign pin_dout = dout_q;
  assign pin_dir  = dir_q;
endmodule

// File: rtl/xirq_edge_unit_chk.sv
module xirq_edge_unit_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_LINES-1:0]   irq,
  input logic [2*NUM_LINES-1:0] cfg_q,
  input logic [NUM_LINES-1:0]   dir_q,
  input logic [NUM_LINES-1:0]   en_q,
  input logic [NUM_LINES-1:0]   flag_q,
  input logic [NUM_LINES-1:0]   clr_v
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (irq == '0 && en_q == '0 && dir_q == '0 && cfg_q == '0));

  a_r10_line0_idle: assert property (@(posedge clk) disable iff (rst)
    irq[0] == 1'b0);

  generate
    for (genvar n = 1; n < NUM_LINES; n++) begin : g_chk
      a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q[n] && !clr_v[n] && cfg_q[2*n +: 2] != 2'b00) |=> flag_q[n]);

      a_r2_level_no_latch: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[2*n +: 2] == 2'b00) |=> !flag_q[n]);

      a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq[n] |-> $past(en_q[n]));

      a_r9_output_silent: assert property (@(posedge clk) disable iff (rst)
        (dir_q[n] && !flag_q[n]) |=> !flag_q[n]);
    end
  endgenerate
endmodule

bind xirq_edge_unit xirq_edge_unit_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .cfg_q(cfg_q), .dir_q(dir_q),
  .en_q(en_q), .flag_q(flag_q), .clr_v(clr_v)
);

// File: tb/xirq_edge_unit_test.sv
`timescale 1ns/1ps
module xirq_edge_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  pin_dout, pin_dir, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  xirq_edge_unit uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_dout(pin_dout), .pin_dir(pin_dir), .irq(irq)
  );

  // reference model, stepped on each rising edge
  logic [7:0]  m_s1, m_s2, m_prev, m_flag, m_dir, m_en, m_dout, m_irq;
  logic [15:0] m_cfg, m_rd;

  function automatic logic [7:0] view_of(logic [15:0] cfg, logic [7:0] dir,
                                         logic [7:0] s2, logic [7:0] flag);
    logic [7:0] v;
    v = '0;
    for (int n = 1; n < 8; n++)
      v[n] = (cfg[2*n +: 2] == 2'b00) ? (~dir[n] & ~s2[n]) : flag[n];
    return v;
  endfunction

  always @(posedge clk) begin : model
    logic [7:0] v, clr, nf;
    logic rise, fall, ev;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0; m_dir <= '0;
      m_en <= '0; m_dout <= '0; m_irq <= '0; m_cfg <= '0; m_rd <= '0;
    end else begin
      v   = view_of(m_cfg, m_dir, m_s2, m_flag);
      clr = (bus_wr && bus_addr == 2'd3 && bus_be[0]) ? (bus_wdata[7:0] & 8'hFE) : 8'h00;
      nf  = '0;
      for (int n = 1; n < 8; n++) begin
        rise = m_s2[n] & ~m_prev[n];
        fall = ~m_s2[n] & m_prev[n];
        case (m_cfg[2*n +: 2])
          2'b01:   ev = rise;
          2'b10:   ev = fall;
          2'b11:   ev = rise | fall;
          default: ev = 1'b0;
        endcase
        ev = ev & ~m_dir[n];
        nf[n] = (m_cfg[2*n +: 2] == 2'b00) ? 1'b0 : (ev | (m_flag[n] & ~clr[n]));
      end
      case (bus_addr)
        2'd0: m_rd <= m_cfg;
        2'd1: m_rd <= {m_dir, m_en};
        2'd2: m_rd <= {m_dout, m_s2 & 8'hFE};
        default: m_rd <= {8'h00, v};
      endcase
      m_irq  <= m_en & v;
      m_flag <= nf;
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: begin
            if (bus_be[0]) m_cfg[7:0]  <= bus_wdata[7:0] & 8'hFC;
            if (bus_be[1]) m_cfg[15:8] <= bus_wdata[15:8];
          end
          2'd1: begin
            if (bus_be[1]) m_dir <= bus_wdata[15:8] & 8'hFE;
            if (bus_be[0]) m_en  <= bus_wdata[7:0] & 8'hFE;
          end
          2'd2: if (bus_be[1]) m_dout <= bus_wdata[15:8] & 8'hFE;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq == m_irq, "R8 irq vs model", irq, m_irq);
      chk(bus_rdata == m_rd, "R13 rdata vs model", bus_rdata, m_rd);
      chk(pin_dout == m_dout && pin_dir == m_dir, "R12 pin outputs vs model",
          {pin_dir, pin_dout}, {m_dir, m_dout});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    pin_in[i] = v;
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(4);

    // R1 reset state
    chk(irq == 8'h00, "R1 irq after reset", irq, 0);
    chk(pin_dir == 8'h00 && pin_dout == 8'h00, "R1 pin outputs after reset", {pin_dir, pin_dout}, 0);
    rd_reg(0, d); chk(d == 16'h0000, "R1 sense reg", d, 16'h0000);
    rd_reg(1, d); chk(d == 16'h0000, "R1 ctrl reg", d, 16'h0000);
    rd_reg(3, d); chk(d == 16'h0000, "R1 flag reg", d, 16'h0000);
    rd_reg(2, d); chk(d == 16'h00FE, "R12 readback idle pins", d, 16'h00FE);

    // R2 level mode on line 2
    wr_reg(1, 2'b01, 16'h0004);
    set_pin(2, 1'b0); idle(5);
    chk(irq[2] == 1'b1, "R2 level request", irq[2], 1);
    rd_reg(3, d); chk(d == 16'h0004, "R2 live flag view", d, 16'h0004);
    set_pin(2, 1'b1); idle(5);
    chk(irq[2] == 1'b0, "R2 level released", irq[2], 0);

    // R3 rising on line 3
    wr_reg(0, 2'b01, 16'h0040);
    wr_reg(1, 2'b01, 16'h0008);
    set_pin(3, 1'b0); idle(5);
    chk(irq[3] == 1'b0, "R3 falling ignored", irq[3], 0);
    set_pin(3, 1'b1); idle(5);
    chk(irq[3] == 1'b1, "R3 rising captured", irq[3], 1);
    set_pin(3, 1'b0); idle(5);
    chk(irq[3] == 1'b1, "R3 flag sticky", irq[3], 1);
    rd_reg(3, d); chk(d == 16'h0008, "R3 flag readback", d, 16'h0008);

    // R6 write-zero no effect, write-one clears
    wr_reg(3, 2'b01, 16'h0000); idle(3);
    chk(irq[3] == 1'b1, "R6 zero write ignored", irq[3], 1);
    wr_reg(3, 2'b01, 16'h0008); idle(3);
    chk(irq[3] == 1'b0, "R6 one write clears", irq[3], 0);
    rd_reg(3, d); chk(d == 16'h0000, "R6 flag cleared", d, 0);

    // R4 falling on line 5, R11 byte lanes
    wr_reg(0, 2'b10, 16'h0800);
    rd_reg(0, d); chk(d == 16'h0840, "R11 upper lane only", d, 16'h0840);
    wr_reg(1, 2'b01, 16'h0020);
    set_pin(5, 1'b0); idle(5);
    chk(irq[5] == 1'b1, "R4 falling captured", irq[5], 1);
    wr_reg(3, 2'b01, 16'h0020); idle(3);
    chk(irq[5] == 1'b0, "R4 cleared", irq[5], 0);
    set_pin(5, 1'b1); idle(5);
    chk(irq[5] == 1'b0, "R4 rising ignored", irq[5], 0);

    // R5 both edges on line 6
    wr_reg(0, 2'b10, 16'h3800);
    rd_reg(0, d); chk(d == 16'h3840, "R11 sense fields kept", d, 16'h3840);
    wr_reg(1, 2'b01, 16'h0040);
    set_pin(6, 1'b0); idle(5);
    chk(irq[6] == 1'b1, "R5 fall captured", irq[6], 1);
    wr_reg(3, 2'b01, 16'h0040); idle(3);
    chk(irq[6] == 1'b0, "R5 cleared", irq[6], 0);
    set_pin(6, 1'b1); idle(5);
    chk(irq[6] == 1'b1, "R5 rise captured", irq[6], 1);

    // R7 edge and clear on the same clock edge (flag6 already set)
    @(negedge clk); pin_in[6] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_addr = 2'd3; bus_be = 2'b01; bus_wdata = 16'h0040; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_be = '0;
    idle(2);
    rd_reg(3, d); chk(d == 16'h0040, "R7 event wins over clear", d, 16'h0040);
    chk(irq[6] == 1'b1, "R7 request kept", irq[6], 1);
    wr_reg(3, 2'b01, 16'h0040); idle(3);

    // R8 capture while disabled
    wr_reg(0, 2'b01, 16'h0044);
    set_pin(1, 1'b0); idle(3);
    set_pin(1, 1'b1); idle(5);
    chk(irq[1] == 1'b0, "R8 disabled no request", irq[1], 0);
    rd_reg(3, d); chk(d == 16'h0002, "R8 flag captured while disabled", d, 16'h0002);
    wr_reg(1, 2'b01, 16'h0042); idle(3);
    chk(irq[1] == 1'b1, "R8 request after enable", irq[1], 1);
    wr_reg(3, 2'b01, 16'h0002); idle(3);

    // R9 output line ignores pin, R12 outputs
    wr_reg(0, 2'b10, 16'h3900);
    wr_reg(1, 2'b11, 16'h1052);
    set_pin(4, 1'b0); idle(3);
    set_pin(4, 1'b1); idle(5);
    chk(irq[4] == 1'b0, "R9 output line no request", irq[4], 0);
    rd_reg(3, d); chk(d[4] == 1'b0, "R9 output line no flag", d, 0);
    chk(pin_dir == 8'h10, "R12 pin_dir", pin_dir, 8'h10);
    wr_reg(2, 2'b11, 16'hA5FF); idle(2);
    chk(pin_dout == 8'hA4, "R12 pin_dout", pin_dout, 8'hA4);
    rd_reg(2, d); chk(d == {8'hA4, pin_in & 8'hFE}, "R12 readback", d, {8'hA4, pin_in & 8'hFE});

    // R10 reserved bit 0
    wr_reg(1, 2'b11, 16'hFFFF);
    rd_reg(1, d); chk(d == 16'hFEFE, "R10 ctrl bit0 ignored", d, 16'hFEFE);
    wr_reg(0, 2'b01, 16'h0003);
    rd_reg(0, d); chk(d == 16'h3900, "R10 line0 sense ignored", d, 16'h3900);
    set_pin(0, 1'b0); idle(5);
    chk(irq[0] == 1'b0, "R10 irq0 quiet", irq[0], 0);
    wr_reg(1, 2'b11, 16'h0000);

    // R13 one-cycle read latency
    @(negedge clk); bus_addr = 2'd0;
    @(negedge clk); bus_addr = 2'd1;
    chk(bus_rdata == 16'h3900, "R13 first read", bus_rdata, 16'h3900);
    @(negedge clk);
    chk(bus_rdata == 16'h0000, "R13 second read", bus_rdata, 16'h0000);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) pin_in = pin_in ^ 8'($urandom_range(255));
      bus_addr  = 2'($urandom_range(3));
      bus_wr    = ($urandom_range(3) == 0);
      bus_be    = 2'($urandom_range(3));
      bus_wdata = 16'($urandom_range(65535));
    end
    @(negedge clk); bus_wr = 1'b0;
    idle(4);
    finish_run();
  end
endmodule